// File: doc/BRIEF.md
# Measured-Boot Sequencer with TPM Traffic Gate

This block controls the measured-boot sequence of a platform and decides what host traffic may reach the TPM. A start request begins the sequence. It asks an external loader to fetch the firmware root section, then a hash engine to digest it, then a signing engine to sign the digest with a volatile key held inside the block. Next it asks the TPM to initialise and writes the upper part of the signature into PCR0. Only after that does it release the stall it places on host firmware fetches. Each step is a request level held until the matching acknowledge arrives. Each wait is bounded by a timeout that sends the sequencer into a fault state, and in that state the stall stays asserted.

Host TPM transactions pass through a gate controlled by the sequencer. Until PCR0 has been written, every host transaction is held off with ready low. Once the platform runs, TPM startup commands are refused at once with an error, and all other traffic is forwarded unchanged. The digest and the signature of the last sequence stay in registers that the host can read back. A new start request clears them.

A tamper input zeroes the key presented to the signing engine in the same cycle and wipes the key register at the next edge. It also aborts any sequence in progress, so no measurement made after the wipe is ever written to PCR0. A start request while no key is held goes straight to the fault state.

Top module: `mboot_gate`

## Requirements
- R1: While reset is held and in the first cycle after it, `fw_stall` is 1, all step requests are 0, `rd_digest` and `rd_sig` are 0, and `h_ready` and `t_valid` are 0.
- R2: The steps go strictly in order: load, hash, sign, TPM initialise, PCR0 write. Each request is raised the cycle after the previous step's acknowledge, and only one request is high at a time.
- R3: While `fw_stall` is 1, `t_valid` and `h_ready` stay 0 whatever the host drives, so a host transaction is held.
- R4: While `fw_stall` is 0, a host transaction with `h_startup` = 1 gets `h_ready` = 1 and `h_err` = 1 in the same cycle, and `t_valid` stays 0.
- R5: While `fw_stall` is 0, a host transaction with `h_startup` = 0 is forwarded: `t_valid` follows `h_valid`, `h_ready` follows `t_ready`, and `h_err` is 0.
- R6: `fw_stall` falls only in the cycle after a PCR0 write has been acknowledged, and it stays 1 through TPM initialise and the PCR0 write.
- R7: `rd_digest` takes `hash_value` when `hash_done` is accepted, and `rd_sig` takes `sign_value` when `sign_done` is accepted. Both then hold until the next accepted start request.
- R8: While `tamper` is 1, `sign_key` is 0 in the same cycle. The held key is erased at the next edge, and the sequencer enters the fault state with `fw_stall` 1.
- R9: If a step's acknowledge does not arrive within `TO_LIMIT` cycles of its request, the sequencer drops the request and enters the fault state with `fw_stall` held at 1. Late acknowledges are then ignored.
- R10: An accepted start request (in idle, run or fault) clears `rd_digest` and `rd_sig` at the same edge that begins the load step.
- R11: `pcr_wr_data` is the upper `PCR_W` bits of the captured signature.
- R12: A start request while no key is held, or after a tamper wipe, raises no load request and leaves the sequencer in the fault state. An aborted sequence never raises `pcr_wr_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | One-cycle request to begin a measured boot |
| tamper | input | 1 | Physical tamper indication |
| key_load | input | 1 | Load `key_seed` into the volatile key register |
| key_seed | input | KEY_W | Freshly generated private key |
| root_load_start | output | 1 | Request to read the root section into local storage |
| root_load_done | input | 1 | Root section read complete |
| hash_start | output | 1 | Request to the hash engine |
| hash_done | input | 1 | Digest ready |
| hash_value | input | DIG_W | Digest of the root section |
| sign_start | output | 1 | Request to the signing engine |
| sign_done | input | 1 | Signature ready |
| sign_value | input | SIG_W | Signature over the digest |
| sign_key | output | KEY_W | Key for the signing engine, zero during tamper |
| tpm_init_req | output | 1 | Request a TPM initialise command |
| tpm_init_ack | input | 1 | TPM initialise done |
| pcr_wr_req | output | 1 | Request a PCR0 write |
| pcr_wr_data | output | PCR_W | Measurement written to PCR0 |
| pcr_wr_ack | input | 1 | PCR0 write done |
| fw_stall | output | 1 | Stall on host firmware fetches |
| h_valid | input | 1 | Host TPM transaction valid |
| h_startup | input | 1 | Host transaction is a TPM startup command |
| h_ready | output | 1 | Host transaction accepted |
| h_err | output | 1 | Accepted transaction was refused |
| t_valid | output | 1 | Forwarded transaction valid toward the TPM |
| t_ready | input | 1 | TPM accepts the forwarded transaction |
| rd_digest | output | DIG_W | Held digest for host readback |
| rd_sig | output | SIG_W | Held signature for host readback |

## Verification
The sequencer reacts one clock after each input. A start request, an acknowledge, a timeout expiry or a tamper edge shows on the request outputs, on `fw_stall` and on the readback registers one cycle later. The gate and the key mask react in the same cycle. The bench drives inputs just after a rising edge. It checks registered results after exactly one further edge, and it checks gate and key-mask results a fraction of a cycle after their inputs change. The timeout is checked on both sides of its boundary: the request is still up after `TO_LIMIT-2` waiting cycles and gone after `TO_LIMIT+1`. Each expected PCR0 value is queued when the bench supplies the signature, and a monitor compares it when the write handshake completes.

// File: rtl/mboot_pkg.sv
// Shared types for the measured-boot sequencer.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package mboot_pkg;

    typedef enum logic [2:0] {
        BS_IDLE  = 3'd0,
        BS_LOAD  = 3'd1,
        BS_HASH  = 3'd2,
        BS_SIGN  = 3'd3,
        BS_TINIT = 3'd4,
        BS_PCRW  = 3'd5,
        BS_RUN   = 3'd6,
        BS_FAULT = 3'd7
    } boot_st_e;

endpackage

// File: rtl/mboot_seq.sv
// Boot step sequencer: walks load, hash, sign, TPM init and PCR0 write,
// bounds each wait with a timeout and aborts on tamper.
// Assumes: acknowledges are one-cycle or level signals sampled while the
// matching request is high; start_req is honoured only in idle, run or fault.
module mboot_seq
    import mboot_pkg::*;
#(
    parameter int TO_LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic tamper,
    input  logic key_valid,
    input  logic root_load_done,
    input  logic hash_done,
    input  logic sign_done,
    input  logic tpm_init_ack,
    input  logic pcr_wr_ack,
    output logic root_load_start,
    output logic hash_start,
    output logic sign_start,
    output logic tpm_init_req,
    output logic pcr_wr_req,
    output logic fw_stall,
    output logic run_mode,
    output logic clr_regs,
    output logic cap_digest,
    output logic cap_sig
);
    localparam int CW = $clog2(TO_LIMIT) + 1;

    boot_st_e      st_q, st_d;
    logic [CW-1:0] wcnt_q;
    logic          waiting, step_done, timed_out, can_start;

    // Which acknowledge belongs to the current step.
    always_comb begin
        waiting   = 1'b1;
        step_done = 1'b0;
        unique case (st_q)
            BS_LOAD:  step_done = root_load_done;
            BS_HASH:  step_done = hash_done;
            BS_SIGN:  step_done = sign_done;
            BS_TINIT: step_done = tpm_init_ack;
            BS_PCRW:  step_done = pcr_wr_ack;
            default:  waiting   = 1'b0;
        endcase
    end

    assign timed_out = waiting && (wcnt_q == CW'(TO_LIMIT - 1));
    assign can_start = (st_q == BS_IDLE) || (st_q == BS_RUN) || (st_q == BS_FAULT);

    // Next-state choice; tamper overrides everything.
    always_comb begin
        st_d       = st_q;
        clr_regs   = 1'b0;
        cap_digest = 1'b0;
        cap_sig    = 1'b0;
        if (tamper) begin
            st_d = BS_FAULT;
        end else if (can_start) begin
            if (start_req) begin
                clr_regs = 1'b1;
                st_d     = key_valid ? BS_LOAD : BS_FAULT;
            end
        end else if (step_done) begin
            unique case (st_q)
                BS_LOAD:  st_d = BS_HASH;
                BS_HASH:  begin st_d = BS_SIGN; cap_digest = 1'b1; end
                BS_SIGN:  begin st_d = BS_TINIT; cap_sig = 1'b1; end
                BS_TINIT: st_d = BS_PCRW;
                default:  st_d = BS_RUN;
            endcase
        end else if (timed_out) begin
            st_d = BS_FAULT;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= BS_IDLE;
        else        st_q <= st_d;
    end

    // Wait counter: restarts on every state change, counts while waiting.
    always_ff @(posedge clk) begin
        if (!rst_n)             wcnt_q <= '0;
        else if (st_d != st_q)  wcnt_q <= '0;
        else if (waiting)       wcnt_q <= wcnt_q + 1'b1;
    end

    assign root_load_start = (st_q == BS_LOAD);
    assign hash_start      = (st_q == BS_HASH);
    assign sign_start      = (st_q == BS_SIGN);
    assign tpm_init_req    = (st_q == BS_TINIT);
    assign pcr_wr_req      = (st_q == BS_PCRW);
    assign run_mode        = (st_q == BS_RUN);
    assign fw_stall        = !run_mode;

    p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hash_start) |-> $past(root_load_done));
    p_onehot_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({root_load_start, hash_start, sign_start, tpm_init_req, pcr_wr_req}));
    p_stall_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fw_stall) |-> $past(pcr_wr_req && pcr_wr_ack));
    p_tamper_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tamper |=> (fw_stall && !pcr_wr_req && !sign_start));
    p_wait_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        waiting |-> (wcnt_q < CW'(TO_LIMIT)));
    p_nokey_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && can_start && !key_valid && !tamper) |=> (!root_load_start && fw_stall));

endmodule

// File: rtl/mboot_vault.sv
// Holds the volatile signing key and the readback digest and signature.
// Assumes: tamper has priority over key_load; clr and the captures never
// coincide (the sequencer issues them in different states).
module mboot_vault #(
    parameter int DIG_W = 32,
    parameter int SIG_W = 32,
    parameter int KEY_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tamper,
    input  logic             key_load,
    input  logic [KEY_W-1:0] key_seed,
    input  logic             clr,
    input  logic             cap_digest,
    input  logic             cap_sig,
    input  logic [DIG_W-1:0] hash_value,
    input  logic [SIG_W-1:0] sign_value,
    output logic [DIG_W-1:0] digest,
    output logic [SIG_W-1:0] sig,
    output logic [KEY_W-1:0] sign_key,
    output logic             key_valid
);
    logic [KEY_W-1:0] key_q;
    logic             kv_q;

    // Key register: wiped by tamper or reset, filled by key_load.
    always_ff @(posedge clk) begin
        if (!rst_n || tamper) begin
            key_q <= '0;
            kv_q  <= 1'b0;
        end else if (key_load) begin
            key_q <= key_seed;
            kv_q  <= 1'b1;
        end
    end

    // Digest readback register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  digest <= '0;
        else if (cap_digest) digest <= hash_value;
    end

    // Signature readback register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) sig <= '0;
        else if (cap_sig)  sig <= sign_value;
    end

    assign sign_key  = tamper ? '0 : key_q;
    assign key_valid = kv_q;

    p_keywipe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tamper |=> (!key_valid && sign_key == '0));
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (digest == '0 && sig == '0));
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !cap_digest && !cap_sig) |=> ($stable(digest) && $stable(sig)));

endmodule

// File: rtl/mboot_tpm_gate.sv
// Host-to-TPM transaction gate: holds everything before run, refuses
// startup commands and forwards the rest once running.
// Assumes: the host keeps h_valid and h_startup steady until h_ready.
module mboot_tpm_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic run_mode,
    input  logic h_valid,
    input  logic h_startup,
    input  logic t_ready,
    output logic h_ready,
    output logic h_err,
    output logic t_valid
);
    logic refuse;

    // Startup commands are answered locally once running.
    assign refuse  = run_mode && h_valid && h_startup;
    assign t_valid = run_mode && h_valid && !h_startup;
    assign h_ready = refuse || (t_valid && t_ready);
    assign h_err   = refuse;

    p_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run_mode |-> (!t_valid && !h_ready && !h_err));
    p_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_mode && h_valid && h_startup) |-> (h_ready && h_err && !t_valid));
    p_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_mode && !h_startup) |-> (t_valid == h_valid && h_ready == (h_valid && t_ready) && !h_err));

endmodule

// File: rtl/mboot_gate.sv
// Top: measured-boot sequencer, key and readback vault, and TPM gate.
// Assumes: external engines follow the request/acknowledge levels and
// PCR_W does not exceed SIG_W.
module mboot_gate
    import mboot_pkg::*;
#(
    parameter int DIG_W    = 32,
    parameter int SIG_W    = 32,
    parameter int KEY_W    = 32,
    parameter int PCR_W    = 16,
    parameter int TO_LIMIT = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             tamper,
    input  logic             key_load,
    input  logic [KEY_W-1:0] key_seed,
    output logic             root_load_start,
    input  logic             root_load_done,
    output logic             hash_start,
    input  logic             hash_done,
    input  logic [DIG_W-1:0] hash_value,
    output logic             sign_start,
    input  logic             sign_done,
    input  logic [SIG_W-1:0] sign_value,
    output logic [KEY_W-1:0] sign_key,
    output logic             tpm_init_req,
    input  logic             tpm_init_ack,
    output logic             pcr_wr_req,
    output logic [PCR_W-1:0] pcr_wr_data,
    input  logic             pcr_wr_ack,
    output logic             fw_stall,
    input  logic             h_valid,
    input  logic             h_startup,
    output logic             h_ready,
    output logic             h_err,
    output logic             t_valid,
    input  logic             t_ready,
    output logic [DIG_W-1:0] rd_digest,
    output logic [SIG_W-1:0] rd_sig
);
    localparam int PCR_LSB = SIG_W - PCR_W;

    logic key_valid, run_mode, clr_regs, cap_digest, cap_sig;

    mboot_seq #(.TO_LIMIT(TO_LIMIT)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .tamper(tamper),
        .key_valid(key_valid), .root_load_done(root_load_done),
        .hash_done(hash_done), .sign_done(sign_done),
        .tpm_init_ack(tpm_init_ack), .pcr_wr_ack(pcr_wr_ack),
        .root_load_start(root_load_start), .hash_start(hash_start),
        .sign_start(sign_start), .tpm_init_req(tpm_init_req),
        .pcr_wr_req(pcr_wr_req), .fw_stall(fw_stall), .run_mode(run_mode),
        .clr_regs(clr_regs), .cap_digest(cap_digest), .cap_sig(cap_sig)
    );

    mboot_vault #(.DIG_W(DIG_W), .SIG_W(SIG_W), .KEY_W(KEY_W)) u_vault (
        .clk(clk), .rst_n(rst_n), .tamper(tamper), .key_load(key_load),
        .key_seed(key_seed), .clr(clr_regs), .cap_digest(cap_digest),
        .cap_sig(cap_sig), .hash_value(hash_value), .sign_value(sign_value),
        .digest(rd_digest), .sig(rd_sig), .sign_key(sign_key),
        .key_valid(key_valid)
    );

    mboot_tpm_gate u_gate (
        .clk(clk), .rst_n(rst_n), .run_mode(run_mode), .h_valid(h_valid),
        .h_startup(h_startup), .t_ready(t_ready), .h_ready(h_ready),
        .h_err(h_err), .t_valid(t_valid)
    );

    // Measurement for PCR0: the upper part of the held signature.
    assign pcr_wr_data = rd_sig[SIG_W-1:PCR_LSB];

    p_pcr_after_sig_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pcr_wr_req) |-> $past(tpm_init_ack));
    p_stall_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fw_stall |-> (!t_valid && !h_ready));

endmodule

// File: tb/sim_mboot_gate.sv
`timescale 1ns/100ps
// Scoreboard bench for mboot_gate: a driver queues expected PCR0 values,
// a monitor compares them on each completed PCR0 write.
module sim_mboot_gate;
    localparam int DW = 32, SW = 32, KW = 32, PW = 16, TO = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_req = 0, tamper = 0, key_load = 0;
    logic [KW-1:0] key_seed = '0;
    logic root_load_start, root_load_done = 0;
    logic hash_start, hash_done = 0;
    logic [DW-1:0] hash_value = '0;
    logic sign_start, sign_done = 0;
    logic [SW-1:0] sign_value = '0;
    logic [KW-1:0] sign_key;
    logic tpm_init_req, tpm_init_ack = 0;
    logic pcr_wr_req, pcr_wr_ack = 0;
    logic [PW-1:0] pcr_wr_data;
    logic fw_stall, h_valid = 0, h_startup = 0, h_ready, h_err, t_valid, t_ready = 0;
    logic [DW-1:0] rd_digest;
    logic [SW-1:0] rd_sig;

    int n_vec = 0, n_bad = 0;
    bit reported = 0;
    logic [KW-1:0] cur_key;
    logic [PW-1:0] exp_q[$];

    always #2 clk = ~clk;

    mboot_gate #(.DIG_W(DW), .SIG_W(SW), .KEY_W(KW), .PCR_W(PW), .TO_LIMIT(TO)) u0 (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .tamper(tamper),
        .key_load(key_load), .key_seed(key_seed),
        .root_load_start(root_load_start), .root_load_done(root_load_done),
        .hash_start(hash_start), .hash_done(hash_done), .hash_value(hash_value),
        .sign_start(sign_start), .sign_done(sign_done), .sign_value(sign_value),
        .sign_key(sign_key), .tpm_init_req(tpm_init_req), .tpm_init_ack(tpm_init_ack),
        .pcr_wr_req(pcr_wr_req), .pcr_wr_data(pcr_wr_data), .pcr_wr_ack(pcr_wr_ack),
        .fw_stall(fw_stall), .h_valid(h_valid), .h_startup(h_startup),
        .h_ready(h_ready), .h_err(h_err), .t_valid(t_valid), .t_ready(t_ready),
        .rd_digest(rd_digest), .rd_sig(rd_sig)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic settle();
        #0.5;
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // Monitor: compare each completed PCR0 write with the queued value (R11).
    always @(negedge clk) begin
        if (rst_n && pcr_wr_req && pcr_wr_ack) begin
            n_vec++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R11/R12: unexpected PCR0 write actual %h expected none", pcr_wr_data);
            end else begin
                logic [PW-1:0] e;
                e = exp_q.pop_front();
                if (pcr_wr_data !== e) begin
                    n_bad++;
                    $display("FAIL R11: actual %h expected %h", pcr_wr_data, e);
                end
            end
        end
    end

    // Driver: one complete measured boot with host traffic pending throughout.
    task automatic do_boot(input logic [DW-1:0] hv, input logic [SW-1:0] sv);
        start_req = 1; tick(); start_req = 0;
        chk(root_load_start === 1'b1, "R2 load req", root_load_start, 1);
        chk(rd_digest === '0 && rd_sig === '0, "R10 cleared", rd_digest, 0);
        h_valid = 1; t_ready = 1; settle();
        chk(!t_valid && !h_ready, "R3 held in load", {t_valid, h_ready}, 0);
        tick(); tick();
        root_load_done = 1; tick(); root_load_done = 0;
        chk(hash_start && !root_load_start, "R2 hash req", {hash_start, root_load_start}, 2);
        hash_value = hv; hash_done = 1; tick(); hash_done = 0;
        chk(sign_start && !hash_start, "R2 sign req", {sign_start, hash_start}, 2);
        chk(rd_digest === hv, "R7 digest", rd_digest, hv);
        chk(sign_key === cur_key, "R8 key to signer", sign_key, cur_key);
        h_startup = 1; settle();
        chk(!h_ready && !h_err && !t_valid, "R3 startup held", {h_ready, h_err, t_valid}, 0);
        h_startup = 0;
        sign_value = sv; sign_done = 1; tick(); sign_done = 0;
        chk(tpm_init_req === 1'b1, "R2 tpm init req", tpm_init_req, 1);
        chk(fw_stall === 1'b1, "R6 stall in init", fw_stall, 1);
        tpm_init_ack = 1; tick(); tpm_init_ack = 0;
        chk(pcr_wr_req && !tpm_init_req, "R2 pcr req", {pcr_wr_req, tpm_init_req}, 2);
        chk(fw_stall && !t_valid, "R6 stall in pcr write", {fw_stall, t_valid}, 2);
        exp_q.push_back(sv[SW-1 -: PW]);
        pcr_wr_ack = 1; tick(); pcr_wr_ack = 0;
        chk(fw_stall === 1'b0, "R6 release", fw_stall, 0);
        chk(rd_sig === sv, "R7 signature", rd_sig, sv);
        h_valid = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        h_valid = 1; t_ready = 1;
        tick(); tick();
        chk(fw_stall && !root_load_start && !hash_start && !pcr_wr_req, "R1 in reset",
            {fw_stall, root_load_start, hash_start, pcr_wr_req}, 8);
        chk(!h_ready && !t_valid && rd_digest === '0 && rd_sig === '0, "R1 outputs",
            {h_ready, t_valid}, 0);
        rst_n = 1; tick();
        chk(fw_stall === 1'b1 && !h_ready && !t_valid, "R1/R3 after reset", {fw_stall, h_ready, t_valid}, 4);
        h_valid = 0;

        // Start with no key: straight to fault.
        start_req = 1; tick(); start_req = 0;
        chk(!root_load_start && fw_stall, "R12 no key", root_load_start, 0);

        cur_key = 32'hC0FFEE11; key_seed = cur_key; key_load = 1; tick(); key_load = 0;
        do_boot(32'h1234ABCD, 32'hBEEF5A5A);

        // Running: forwarding and refusal.
        h_valid = 1; h_startup = 0; t_ready = 0; settle();
        chk(t_valid && !h_ready && !h_err, "R5 forward wait", {t_valid, h_ready, h_err}, 4);
        t_ready = 1; settle();
        chk(t_valid && h_ready && !h_err, "R5 forward accept", {t_valid, h_ready, h_err}, 6);
        h_startup = 1; settle();
        chk(h_ready && h_err && !t_valid, "R4 startup refused", {h_ready, h_err, t_valid}, 6);
        h_startup = 0; h_valid = 0; tick(); tick(); tick();
        chk(rd_digest === 32'h1234ABCD && rd_sig === 32'hBEEF5A5A, "R7 held", rd_digest, 32'h1234ABCD);

        // Second boot: start clears, new values measured.
        do_boot(32'h0F0F0001, 32'h77661234);

        // Timeout while waiting for the digest.
        start_req = 1; tick(); start_req = 0;
        root_load_done = 1; tick(); root_load_done = 0;
        repeat (TO - 2) tick();
        chk(hash_start === 1'b1, "R9 not early", hash_start, 1);
        repeat (3) tick();
        chk(!hash_start && fw_stall, "R9 timeout fault", {hash_start, fw_stall}, 1);
        hash_done = 1; tick(); hash_done = 0;
        chk(!sign_start && fw_stall, "R9 late ack ignored", sign_start, 0);

        // Tamper during signing.
        start_req = 1; tick(); start_req = 0;
        root_load_done = 1; tick(); root_load_done = 0;
        hash_value = 32'hAAAA5555; hash_done = 1; tick(); hash_done = 0;
        chk(sign_start === 1'b1 && sign_key === cur_key, "R8 before tamper", sign_key, cur_key);
        tamper = 1; settle();
        chk(sign_key === '0, "R8 key masked at once", sign_key, 0);
        tick(); tamper = 0;
        chk(!sign_start && fw_stall && sign_key === '0, "R8 wiped and fault", sign_key, 0);
        sign_value = 32'hDEAD0000; sign_done = 1; tick(); sign_done = 0;
        chk(!tpm_init_req && !pcr_wr_req, "R12 aborted", {tpm_init_req, pcr_wr_req}, 0);
        start_req = 1; tick(); start_req = 0;
        chk(!root_load_start && fw_stall, "R12 wiped key start", root_load_start, 0);
        chk(rd_digest === '0, "R10 clear on start", rd_digest, 0);

        // Re-key and recover.
        cur_key = 32'h5EED0002; key_seed = cur_key; key_load = 1; tick(); key_load = 0;
        do_boot(32'hCAFE0003, 32'h13579BDF);
        tick();
        chk(exp_q.size() == 0, "R11 all writes seen", exp_q.size(), 0);
        report();
    end
endmodule